// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block produces the two compare pulses that a frequency synthesizer loop needs. On the VCO side it divides the oscillator clock by a loadable integer N. The divider uses a dual-modulus prescaler (divide by 32 or 33), a swallow counter and a slower main counter. Software supplies only N. The hardware splits N into a swallow count (N mod 32) and a main count (N div 32). On the reference side a fixed counter divides the reference clock by 65. With a 13 MHz reference this gives a 200 kHz compare rate. In lock the synthesized frequency is N × fref / 65.

A new N is taken in with a one-cycle load strobe on the VCO clock. It waits in a holding register and takes over only at the end of the feedback cycle in progress, so no shortened or stretched cycle ever reaches the phase detector. The two-modulus scheme gives an exact divide only when the main count is at least 31, so N must be at least 32 × 31 = 992. A smaller value is refused, and an error flag records the refusal.

Top module: `pss_divider`

## Requirements
- R1: For any active N of 992 or more, `fb_pulse` rises once every N cycles of `clk_vco`.
- R2: Each feedback cycle has N div 32 prescaler periods, of which N mod 32 last 33 VCO cycles and the others last 32. N values with swallow count 0 and swallow count 31 both divide exactly.
- R3: A load with `n_value` below 992 sets `n_bad` to 1 on the next `clk_vco` edge and leaves the active divide ratio unchanged.
- R4: A load with `n_value` of 992 or more clears `n_bad` to 0 on the next `clk_vco` edge.
- R5: A valid load made partway through a feedback cycle does not change that cycle's length. The new N sets the length of the cycle that starts at the next feedback boundary.
- R6: `fb_pulse` is high for exactly one `clk_vco` cycle per feedback cycle.
- R7: `ref_pulse` is high for exactly one `clk_ref` cycle in every 65 `clk_ref` cycles.
- R8: While `rst_n` is low, `fb_pulse`, `ref_pulse` and `n_bad` are 0. After reset the active N is the parameter `N_RESET` (default 1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Oscillator-rate clock being divided |
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| n_load | input | 1 | One-cycle strobe on `clk_vco` that offers `n_value` |
| n_value | input | N_W (18) | Requested feedback divide ratio |
| fb_pulse | output | 1 | One-cycle pulse per N VCO cycles |
| ref_pulse | output | 1 | One-cycle pulse per 65 reference cycles |
| n_bad | output | 1 | Last offered ratio was below 992 and was refused |

## Verification
Several properties are checked on every cycle. Both pulses are one cycle wide. The prescaler count never passes 32. The swallow remainder never exceeds the main remainder, which is what keeps the split exact. No interval between feedback pulses is shorter than the minimum legal N. A refused load always raises the flag. The exact interval for a given N can only be shown by the bench's scenarios, which measure the spacing of feedback pulses in VCO cycles. The same holds for the deferral of a mid-cycle load to the next boundary and for the unchanged ratio after a refused load.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // swallow count: number of P+1 prescaler periods in one feedback cycle
  function automatic int unsigned swallow_of(input int unsigned n, input int unsigned plog2);
    return n & ((32'd1 << plog2) - 32'd1);
  endfunction

  // main count: total prescaler periods in one feedback cycle
  function automatic int unsigned main_of(input int unsigned n, input int unsigned plog2);
    return n >> plog2;
  endfunction

  // smallest N for which the two-modulus split is exact: P*(P-1)
  function automatic int unsigned n_floor(input int unsigned plog2);
    return (32'd1 << plog2) * ((32'd1 << plog2) - 32'd1);
  endfunction

endpackage

// File: rtl/pss_prescaler.sv
module pss_prescaler #(
  parameter int P_LOG2 = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            next_hi,
  output logic            pre_end,
  output logic [P_LOG2:0] pc_o
);
  localparam logic [P_LOG2:0] PC_HI = (P_LOG2+1)'(32'd1 << P_LOG2);
  localparam logic [P_LOG2:0] PC_LO = PC_HI - 1'b1;

  logic [P_LOG2:0] pc;

  assign pre_end = (pc == '0);
  assign pc_o    = pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (pre_end) pc <= next_hi ? PC_HI : PC_LO;
    else              pc <= pc - 1'b1;
  end
endmodule

// File: rtl/pss_swallow_ctrl.sv
module pss_swallow_ctrl
  import pss_pkg::*;
#(
  parameter int N_W     = 18,
  parameter int P_LOG2  = 5,
  parameter int N_RESET = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_end,
  input  logic              n_load,
  input  logic [N_W-1:0]    n_value,
  output logic              next_hi,
  output logic              fb_edge,
  output logic              fb_pulse,
  output logic              n_bad,
  output logic [P_LOG2-1:0] a_rem_o,
  output logic [N_W-P_LOG2-1:0] m_rem_o
);
  localparam int M_W = N_W - P_LOG2;
  localparam logic [N_W-1:0] N_MIN = N_W'(n_floor(P_LOG2));

  logic [N_W-1:0]    n_act, n_hold, n_next;
  logic              pend, load_ok;
  logic [P_LOG2-1:0] a_rem, a_new;
  logic [M_W-1:0]    m_rem, m_new;

  assign load_ok = n_load && (n_value >= N_MIN);
  assign n_next  = pend ? n_hold : n_act;
  assign a_new   = P_LOG2'(swallow_of(32'(n_next), P_LOG2));
  assign m_new   = M_W'(main_of(32'(n_next), P_LOG2));
  assign fb_edge = pre_end && (m_rem == '0);
  assign next_hi = fb_edge ? (a_new != '0) : (a_rem != '0);
  assign a_rem_o = a_rem;
  assign m_rem_o = m_rem;

  // counts for the running feedback cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rem <= '0;
      m_rem <= '0;
      n_act <= N_W'(N_RESET);
    end else if (fb_edge) begin
      a_rem <= (a_new != '0) ? a_new - 1'b1 : '0;
      m_rem <= m_new - 1'b1;
      n_act <= n_next;
    end else if (pre_end) begin
      m_rem <= m_rem - 1'b1;
      if (a_rem != '0) a_rem <= a_rem - 1'b1;
    end
  end

  // holding register for a new ratio, applied at the boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_hold <= '0;
      pend   <= 1'b0;
      n_bad  <= 1'b0;
    end else begin
      if (n_load) n_bad <= !load_ok;
      if (load_ok) begin
        n_hold <= n_value;
        pend   <= 1'b1;
      end else if (fb_edge) begin
        pend   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_pulse <= 1'b0;
    else        fb_pulse <= fb_edge;
  end
endmodule

// File: rtl/pss_ref_div.sv
module pss_ref_div #(
  parameter int REF_DIV = 65
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_pulse
);
  localparam int RC_W = $clog2(REF_DIV);
  localparam logic [RC_W-1:0] RC_TOP = RC_W'(REF_DIV - 1);

  logic [RC_W-1:0] cnt;
  logic            wrap;

  assign wrap = (cnt == RC_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ref_pulse <= 1'b0;
    end else begin
      cnt       <= wrap ? '0 : cnt + 1'b1;
      ref_pulse <= wrap;
    end
  end
endmodule

// File: rtl/pss_divider.sv
module pss_divider #(
  parameter int N_W     = 18,
  parameter int P_LOG2  = 5,
  parameter int N_RESET = 1000,
  parameter int REF_DIV = 65
) (
  input  logic           clk_vco,
  input  logic           clk_ref,
  input  logic           rst_n,
  input  logic           n_load,
  input  logic [N_W-1:0] n_value,
  output logic           fb_pulse,
  output logic           ref_pulse,
  output logic           n_bad
);
  localparam int M_W = N_W - P_LOG2;

  // internal events, named for the checker
  logic              pre_end;
  logic              next_hi;
  logic              fb_edge;
  logic [P_LOG2:0]   pc;
  logic [P_LOG2-1:0] a_rem;
  logic [M_W-1:0]    m_rem;

  pss_prescaler #(.P_LOG2(P_LOG2)) u_pre (
    .clk     (clk_vco),
    .rst_n   (rst_n),
    .next_hi (next_hi),
    .pre_end (pre_end),
    .pc_o    (pc)
  );

  pss_swallow_ctrl #(.N_W(N_W), .P_LOG2(P_LOG2), .N_RESET(N_RESET)) u_ctl (
    .clk      (clk_vco),
    .rst_n    (rst_n),
    .pre_end  (pre_end),
    .n_load   (n_load),
    .n_value  (n_value),
    .next_hi  (next_hi),
    .fb_edge  (fb_edge),
    .fb_pulse (fb_pulse),
    .n_bad    (n_bad),
    .a_rem_o  (a_rem),
    .m_rem_o  (m_rem)
  );

  pss_ref_div #(.REF_DIV(REF_DIV)) u_ref (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse)
  );
endmodule

// File: rtl/pss_divider_chk.sv
module pss_divider_chk
  import pss_pkg::*;
#(
  parameter int N_W    = 18,
  parameter int P_LOG2 = 5
) (
  input logic                    clk_vco,
  input logic                    clk_ref,
  input logic                    rst_n,
  input logic                    n_load,
  input logic [N_W-1:0]          n_value,
  input logic                    fb_pulse,
  input logic                    ref_pulse,
  input logic                    n_bad,
  input logic                    fb_edge,
  input logic [P_LOG2:0]         pc,
  input logic [P_LOG2-1:0]       a_rem,
  input logic [N_W-P_LOG2-1:0]   m_rem
);
  localparam int unsigned N_MIN = n_floor(P_LOG2);

  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (fb_pulse) begin
      gap  <= 1;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 1;
    end
  end

  AST_FB_ONE_CYCLE: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R6

  AST_FB_FOLLOWS_EDGE: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_edge |=> fb_pulse); // R1

  AST_REF_ONE_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse); // R7

  AST_PRESCALE_RANGE: assert property (@(posedge clk_vco) disable iff (!rst_n)
    pc <= (P_LOG2+1)'(32'd1 << P_LOG2)); // R2

  AST_SWALLOW_FITS: assert property (@(posedge clk_vco) disable iff (!rst_n)
    32'(a_rem) <= 32'(m_rem)); // R2

  AST_PERIOD_FLOOR: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (seen && fb_pulse) |-> gap >= N_MIN); // R3

  AST_BAD_FLAG: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (n_load && (32'(n_value) < N_MIN)) |=> n_bad); // R3

  AST_GOOD_CLEARS: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (n_load && (32'(n_value) >= N_MIN)) |=> !n_bad); // R4
endmodule

bind pss_divider pss_divider_chk #(.N_W(N_W), .P_LOG2(P_LOG2)) u_chk (
  .clk_vco   (clk_vco),
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .n_load    (n_load),
  .n_value   (n_value),
  .fb_pulse  (fb_pulse),
  .ref_pulse (ref_pulse),
  .n_bad     (n_bad),
  .fb_edge   (fb_edge),
  .pc        (pc),
  .a_rem     (a_rem),
  .m_rem     (m_rem)
);

// File: tb/pss_divider_bench.sv
`timescale 1ns/1ps
module pss_divider_bench;
  localparam int NW = 18;

  logic          clk_vco = 1'b0;
  logic          clk_ref = 1'b0;
  logic          rst_n   = 1'b0;
  logic          n_load  = 1'b0;
  logic [NW-1:0] n_value = '0;
  logic          fb_pulse, ref_pulse, n_bad;

  int checks = 0;
  int errors = 0;

  always #10 clk_vco = ~clk_vco;   // 50 MHz
  always #13 clk_ref = ~clk_ref;

  pss_divider u_pss_divider (
    .clk_vco   (clk_vco),
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .n_load    (n_load),
    .n_value   (n_value),
    .fb_pulse  (fb_pulse),
    .ref_pulse (ref_pulse),
    .n_bad     (n_bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_fb();
    do @(negedge clk_vco); while (!fb_pulse);
  endtask

  task automatic meas_fb(output int per);
    sync_fb();
    per = 0;
    do begin @(negedge clk_vco); per++; end while (!fb_pulse);
  endtask

  task automatic load_n(input int v);
    @(negedge clk_vco);
    n_load  = 1'b1;
    n_value = NW'(v);
    @(negedge clk_vco);
    n_load  = 1'b0;
  endtask

  task automatic t_reset();
    int per;
    repeat (5) @(negedge clk_vco);
    chk(fb_pulse == 1'b0, "R8 fb_pulse in reset", fb_pulse, 0);
    chk(ref_pulse == 1'b0, "R8 ref_pulse in reset", ref_pulse, 0);
    chk(n_bad == 1'b0, "R8 n_bad in reset", n_bad, 0);
    rst_n = 1'b1;
    meas_fb(per);
    chk(per == 1000, "R8 default ratio", per, 1000);
  endtask

  task automatic t_ratio(input int n);
    int per;
    load_n(n);
    chk(n_bad == 1'b0, "R4 valid load flag", n_bad, 0);
    meas_fb(per);
    chk(per == n, $sformatf("R1 R2 period N=%0d swallow=%0d", n, n % 32), per, n);
  endtask

  task automatic t_width();
    int hi = 0;
    sync_fb();
    do begin hi++; @(negedge clk_vco); end while (fb_pulse);
    chk(hi == 1, "R6 feedback pulse width", hi, 1);
  endtask

  task automatic t_refused(input int cur);
    int per;
    load_n(991);
    chk(n_bad == 1'b1, "R3 flag on 991", n_bad, 1);
    meas_fb(per);
    chk(per == cur, "R3 ratio kept after refusal", per, cur);
    load_n(1200);
    chk(n_bad == 1'b0, "R4 flag cleared", n_bad, 0);
    meas_fb(per);
    chk(per == 1200, "R4 new ratio 1200", per, 1200);
  endtask

  task automatic t_midcycle();
    int per;
    sync_fb();
    per = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk_vco); per++; end
    n_load  = 1'b1;
    n_value = NW'(1500);
    @(negedge clk_vco); per++;
    n_load  = 1'b0;
    while (!fb_pulse) begin @(negedge clk_vco); per++; end
    chk(per == 1200, "R5 running cycle keeps old ratio", per, 1200);
    per = 0;
    do begin @(negedge clk_vco); per++; end while (!fb_pulse);
    chk(per == 1500, "R5 next cycle uses new ratio", per, 1500);
  endtask

  task automatic t_ref();
    int per, hi;
    do @(negedge clk_ref); while (!ref_pulse);
    hi = 0;
    do begin hi++; @(negedge clk_ref); end while (ref_pulse);
    chk(hi == 1, "R7 reference pulse width", hi, 1);
    per = hi;
    while (!ref_pulse) begin @(negedge clk_ref); per++; end
    chk(per == 65, "R7 reference period", per, 65);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio(992);    // smallest legal, swallow 0
    t_ratio(1055);   // swallow 31, main 32
    t_width();
    t_ratio(2080);
    t_ratio(4127);   // swallow 31, main 128
    t_ratio(1055);
    t_refused(1055);
    t_midcycle();
    t_ref();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule